// File: doc/BRIEF.md
# Framebuffer Control Register Window with End-of-Frame Interrupt

This block is the small control and status register window of a framebuffer controller. It spans 32 byte addresses on a byte-wide register bus. A control byte carries an interrupt enable in its top bit. A status byte reports a sticky end-of-frame interrupt, merged with hard-wired monitor-type and colour-board identification bits. Fourteen general byte registers fill the rest of the upper half of the window. The lower half is unmapped.

The display timing logic pulses `frame_done` once per completed frame. When the enable bit is set, that pulse latches a pending flag, which drives the level interrupt line `irq`. Software services the interrupt by writing any value to the status byte. The written value is discarded, and the write only acknowledges the interrupt. Read data is registered and appears on `bus_rdata` in the cycle after the read request.

Top module: `fbr_ctrl_regs`

## Requirements
- R1: After reset, `irq` is 0, the control byte reads 0x00, the status byte reads 0x61, and every general register reads 0x00.
- R2: The control byte at offset 0x10 stores all 8 written bits and reads them back unchanged.
- R3: A `frame_done` pulse while control bit 7 (value 0x80) is 1 sets the pending flag (status bit 7), and `irq` is 1 from the following cycle. The enable value used is the one stored before that clock edge.
- R4: A `frame_done` pulse while control bit 7 is 0 leaves the pending flag and `irq` unchanged.
- R5: A read of offset 0x11 returns 0x61 when nothing is pending and 0xE1 when the pending flag is set. Bits 6..5 (0x60) are the fixed monitor code, bit 0 (0x01) is the fixed colour-board flag, and bit 7 is the pending flag.
- R6: A write of any data to offset 0x11 clears the pending flag, and `irq` is 0 from the next cycle. The data is not stored: the status byte then reads 0x61.
- R7: If a status write and an enabled `frame_done` occur in the same cycle, the pending flag is 1 afterwards and `irq` stays high.
- R8: Offsets 0x12 through 0x1F are independent 8-bit registers. Each reads back the last value written to it, and a write to one leaves the others unchanged.
- R9: Offsets 0x00 through 0x0F read as 0x00. Writes to them change no register in the window.
- R10: `bus_rdata` takes the read value in the cycle after a read request (`bus_sel`=1, `bus_we`=0) and holds its value in every other cycle.
- R11: Clearing control bit 7 does not clear an already pending interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle end-of-frame pulse from the display timing logic |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt, high while an end-of-frame event is pending |

## Verification
Every result is due exactly one clock edge after its stimulus:
- a stored register or the pending flag changes at the edge that samples the access or pulse;
- `irq` follows the pending flag at that same edge;
- `bus_rdata` shows the value the window held just before the read edge.

The bench drives each stimulus on a falling edge and compares on the next falling edge. Its reference model is updated from the state held before that stimulus, so that a read and a simultaneous pulse are judged the way the hardware judges them. In non-read cycles the bench checks that `bus_rdata` keeps its previous value.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  // Which part of the window an offset falls in
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CTRL = 2'd1,
    RGN_STAT = 2'd2,
    RGN_GP   = 2'd3
  } region_e;

  localparam int unsigned IRQ_EN_BIT  = 7;
  localparam int unsigned PEND_BIT    = 7;
  localparam logic [7:0]  MONITOR_ID  = 8'h60;
  localparam logic [7:0]  COLOUR_FLAG = 8'h01;

  // Status byte as seen on a read: fixed identity bits plus sticky pending
  function automatic logic [7:0] status_byte(input logic pending);
    logic [7:0] v;
    v = MONITOR_ID | COLOUR_FLAG;
    v[PEND_BIT] = pending;
    return v;
  endfunction

  // Next pending state; a new enabled event outranks an acknowledge
  function automatic logic next_pending(input logic cur, input logic event_en,
                                        input logic ack);
    logic n;
    if (event_en)  n = 1'b1;
    else if (ack)  n = 1'b0;
    else           n = cur;
    return n;
  endfunction

endpackage

// File: rtl/fbr_decode.sv
module fbr_decode
  import fbr_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CTRL_OFS = 16,
  parameter int STAT_OFS = 17,
  parameter int GP_FIRST = 18,
  parameter int GP_LAST  = 31,
  parameter int IDX_W    = 4
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic              wr_gp,
  output logic              rd_req,
  output logic [IDX_W-1:0]  gp_idx
);

  function automatic region_e classify(input logic [ADDR_W-1:0] a);
    region_e r;
    if (a == ADDR_W'(CTRL_OFS))                            r = RGN_CTRL;
    else if (a == ADDR_W'(STAT_OFS))                       r = RGN_STAT;
    else if (a >= ADDR_W'(GP_FIRST) && a <= ADDR_W'(GP_LAST)) r = RGN_GP;
    else                                                    r = RGN_NONE;
    return r;
  endfunction

  logic [ADDR_W-1:0] rel;

  always_comb begin
    region  = classify(addr);
    rel     = addr - ADDR_W'(GP_FIRST);
    gp_idx  = rel[IDX_W-1:0];
    rd_req  = sel && !we;
    wr_ctrl = sel && we && (region == RGN_CTRL);
    wr_stat = sel && we && (region == RGN_STAT);
    wr_gp   = sel && we && (region == RGN_GP);
  end

endmodule

// File: rtl/fbr_gp_file.sv
module fbr_gp_file #(
  parameter int NUM   = 14,
  parameter int DW    = 8,
  parameter int IDX_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [DW-1:0]            rd_data,
  output logic [NUM-1:0][DW-1:0]   regs
);

  genvar g;
  generate
    for (g = 0; g < NUM; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)                                regs[g] <= '0;
        else if (wr_en && wr_idx == IDX_W'(g))     regs[g] <= wr_data;
      end

      // A write aimed elsewhere leaves this byte alone
      p_only_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != IDX_W'(g)) |=> $stable(regs[g]));
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM; i++)
      if (rd_idx == IDX_W'(i)) rd_data = regs[i];
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));

endmodule

// File: rtl/fbr_vsync_irq.sv
module fbr_vsync_irq
  import fbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic irq_en,
  input  logic ack,
  output logic pending
);

  logic event_en;
  assign event_en = frame_done && irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= next_pending(pending, event_en, ack);
  end

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    event_en |=> pending);
  p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !irq_en && !ack) |=> $stable(pending));
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !event_en) |=> !pending);
  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && event_en) |=> pending);
  p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);

endmodule

// File: rtl/fbr_ctrl_regs.sv
module fbr_ctrl_regs
  import fbr_pkg::*;
#(
  parameter int WIN_BYTES = 32,
  parameter int DW        = 8,
  parameter int CTRL_OFS  = 16,
  parameter int STAT_OFS  = 17,
  parameter int GP_FIRST  = 18,
  localparam int AW       = $clog2(WIN_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_done,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);

  localparam int GP_LAST = WIN_BYTES - 1;
  localparam int NUM_GP  = GP_LAST - GP_FIRST + 1;
  localparam int IDX_W   = (NUM_GP > 1) ? $clog2(NUM_GP) : 1;

  region_e              region;
  logic                 wr_ctrl, wr_stat, wr_gp, rd_req;
  logic [IDX_W-1:0]     gp_idx;
  logic [DW-1:0]        ctrl_q;
  logic                 pending;
  logic [DW-1:0]        gp_rd;
  logic [NUM_GP-1:0][DW-1:0] gp_regs;
  logic [DW-1:0]        rd_next;

  fbr_decode #(
    .ADDR_W(AW), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS),
    .GP_FIRST(GP_FIRST), .GP_LAST(GP_LAST), .IDX_W(IDX_W)
  ) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .region(region), .wr_ctrl(wr_ctrl), .wr_stat(wr_stat),
    .wr_gp(wr_gp), .rd_req(rd_req), .gp_idx(gp_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata;
  end

  fbr_vsync_irq u_irq (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
    .irq_en(ctrl_q[IRQ_EN_BIT]), .ack(wr_stat), .pending(pending)
  );

  assign irq = pending;

  fbr_gp_file #(.NUM(NUM_GP), .DW(DW), .IDX_W(IDX_W)) u_gp (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_gp), .wr_idx(gp_idx),
    .wr_data(bus_wdata), .rd_idx(gp_idx), .rd_data(gp_rd), .regs(gp_regs)
  );

  always_comb begin
    unique case (region)
      RGN_CTRL: rd_next = ctrl_q;
      RGN_STAT: rd_next = DW'(status_byte(pending));
      RGN_GP:   rd_next = gp_rd;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_next;
  end

  p_single_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ctrl, wr_stat, wr_gp}));
  p_status_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && region == RGN_STAT) |=> (bus_rdata[6:0] == 7'h61 && bus_rdata[7] == $past(irq)));
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && region == RGN_NONE) |=> bus_rdata == '0);
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(bus_rdata));
  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q == $past(bus_wdata));

endmodule

// File: tb/fbr_ctrl_regs_test.sv
`timescale 1ns/100ps
module fbr_ctrl_regs_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_done = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [7:0] m_ctrl;
  logic       m_pend;
  logic [7:0] m_gp [0:31];
  logic [7:0] m_rdata;

  always #2.5 clk = ~clk;

  fbr_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] expect_read(input logic [4:0] a);
    if (a == 5'h10)                    return m_ctrl;
    if (a == 5'h11)                    return m_pend ? 8'hE1 : 8'h61;
    if (a >= 5'h12)                    return m_gp[a];
    return 8'h00;
  endfunction

  task automatic compare(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive on falling edge, judge on the next falling edge
  task automatic cycle(input string tag, input logic sel, input logic we,
                       input logic [4:0] a, input logic [7:0] d, input logic fd);
    logic [7:0] rexp;
    logic       pnext;
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d; frame_done = fd;
    rexp  = expect_read(a);
    pnext = m_pend;
    if (fd && m_ctrl[7])                     pnext = 1'b1;
    else if (sel && we && a == 5'h11)        pnext = 1'b0;
    if (sel && we) begin
      if (a == 5'h10)      m_ctrl = d;
      else if (a >= 5'h12) m_gp[a] = d;
    end
    if (sel && !we) m_rdata = rexp;
    m_pend = pnext;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; frame_done = 1'b0;
    compare(tag, "irq", {7'd0, irq}, {7'd0, m_pend});
    if (sel && !we) compare(tag, "read", bus_rdata, m_rdata);
    else            compare("R10", "rdata hold", bus_rdata, m_rdata);
  endtask

  task automatic wr(input string tag, input logic [4:0] a, input logic [7:0] d);
    cycle(tag, 1'b1, 1'b1, a, d, 1'b0);
  endtask
  task automatic rd(input string tag, input logic [4:0] a);
    cycle(tag, 1'b1, 1'b0, a, 8'h00, 1'b0);
  endtask
  task automatic frame(input string tag);
    cycle(tag, 1'b0, 1'b0, 5'h00, 8'h00, 1'b1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual hang, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5EED_0042);
    m_ctrl = 0; m_pend = 0; m_rdata = 0;
    for (int i = 0; i < 32; i++) m_gp[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    compare("R1", "irq after reset", {7'd0, irq}, 8'h00);
    rd("R1", 5'h10);
    rd("R1", 5'h11);
    rd("R1", 5'h12);
    rd("R1", 5'h1F);

    // R2 control byte
    wr("R2", 5'h10, 8'h5A);
    rd("R2", 5'h10);
    wr("R2", 5'h10, 8'h80);
    rd("R2", 5'h10);

    // R3 / R5 enabled frame sets pending
    frame("R3");
    rd("R5", 5'h11);

    // R6 any write acknowledges
    wr("R6", 5'h11, 8'hFF);
    rd("R6", 5'h11);

    // R7 event and acknowledge together
    frame("R7");
    cycle("R7", 1'b1, 1'b1, 5'h11, 8'h00, 1'b1);
    rd("R7", 5'h11);

    // R11 disabling keeps pending; R4 masked frame
    wr("R11", 5'h10, 8'h7F);
    rd("R11", 5'h11);
    frame("R4");
    wr("R6", 5'h11, 8'h80);
    frame("R4");
    rd("R4", 5'h11);

    // R8 general registers
    wr("R8", 5'h12, 8'hA5);
    wr("R8", 5'h1F, 8'h3C);
    wr("R8", 5'h17, 8'h96);
    rd("R8", 5'h12);
    rd("R8", 5'h1F);
    rd("R8", 5'h17);
    rd("R8", 5'h13);

    // R9 unmapped offsets
    wr("R9", 5'h05, 8'hFF);
    wr("R9", 5'h0F, 8'h80);
    rd("R9", 5'h05);
    rd("R9", 5'h00);
    rd("R9", 5'h12);
    rd("R9", 5'h10);

    // R10 a read followed by idle cycles
    rd("R10", 5'h17);
    cycle("R10", 1'b0, 1'b0, 5'h12, 8'h00, 1'b0);
    cycle("R10", 1'b0, 1'b1, 5'h12, 8'h44, 1'b0);

    // random mix: R2 R3 R4 R5 R6 R7 R8 R9
    for (int n = 0; n < 4000; n++) begin
      int unsigned op;
      logic fd;
      logic [4:0] a;
      logic [7:0] d;
      op = $urandom % 8;
      fd = ($urandom % 6) == 0;
      a  = 5'($urandom);
      d  = 8'($urandom);
      case (op)
        0, 1: cycle("R5", 1'b1, 1'b0, a, d, fd);
        2:    cycle("R2", 1'b1, 1'b1, 5'h10, (($urandom % 4) != 0) ? (d | 8'h80) : (d & 8'h7F), fd);
        3:    cycle("R6", 1'b1, 1'b1, 5'h11, d, fd);
        4, 5: cycle("R8", 1'b1, 1'b1, a, d, fd);
        default: cycle("R3", 1'b0, 1'b0, a, d, fd);
      endcase
    end

    done = 1;
    summary();
    $finish;
  end

endmodule